// File: doc/BRIEF.md
# Object Range Tracker

The tracker watches the stream of retired load and store operations and learns, for each distinct base address, the window of offsets the program has used around it. Each record that enters carries the index of the base register, the value of that base and a signed offset. A small fully associative table keeps one entry per base address, with the smallest and largest offset seen so far. A summarizer later walks the table through a combinational read port.

The block only observes. It has no ready signal and never holds up the pipeline that feeds it. A single-record buffer takes the input. A two-step engine, which compares in one cycle and writes in the next, empties the buffer. A record that finds the buffer occupied and not being emptied is discarded and counted. Accesses relative to the global pointer or the stack pointer describe no object, so they are filtered out at the input. When the table is full, a new base replaces the oldest allocation in round-robin order. A clear input empties the table and any record in flight.

Top module: `obj_range_tracker`

## Requirements
- R1: After reset every entry reads invalid (`rdValid` low for every index) and `dropCount` is 0.
- R2: A record whose base matches no valid entry is written into the lowest-numbered invalid entry, with minimum and maximum both equal to its offset. If the record is sampled at clock edge k, the read port shows the entry after edge k+3.
- R3: A record whose base matches a valid entry lowers that entry's minimum when its offset is smaller and raises its maximum when its offset is larger. Offsets are two's-complement signed. The base register index plays no part in matching, and an offset inside the window changes nothing.
- R4: A record whose base register index equals `GP_REG` (default 3) or `SP_REG` (default 2) allocates nothing, updates nothing and is not counted as dropped.
- R5: When every entry is valid, a missing base replaces the entry allocated longest ago. Victims are taken in round-robin order starting from entry 0 after reset or clear.
- R6: The engine takes at most one record every two cycles from a one-record buffer. A record that arrives while the buffer is full and is not being emptied in that cycle is discarded and increments `dropCount` by one. The count saturates at its all-ones value.
- R7: A `clear` pulse invalidates every entry by the next cycle, discards any buffered or in-flight record and any record presented in the same cycle, restarts the round-robin at entry 0, and leaves `dropCount` unchanged.
- R8: The read port is combinational: `rdValid`, `rdBase`, `rdMin` and `rdMax` reflect entry `rdIdx` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Invalidate all entries and flush pending records |
| recValid | input | 1 | A retired memory record is present this cycle |
| recBaseReg | input | REG_W | Index of the base register used by the access |
| recBase | input | ADDR_W | Value of the base register |
| recOffset | input | OFF_W | Signed offset added to the base |
| rdIdx | input | IDX_W | Entry selected on the read port |
| rdValid | output | 1 | Selected entry holds a base |
| rdBase | output | ADDR_W | Base address of the selected entry |
| rdMin | output | OFF_W | Smallest offset seen for that base (signed) |
| rdMax | output | OFF_W | Largest offset seen for that base (signed) |
| dropCount | output | DROP_W | Saturating count of discarded records |

## Verification
The properties assume that the entry count is a power of two, so that every value of `rdIdx` selects a real entry, and that `clear` never coincides with reset. They also assume that `rdIdx` is the only thing that moves the read port apart from committed updates. The stimulus therefore holds `rdIdx` steady while records settle and uses the default four-entry table. Records are driven on the falling edge, one per cycle at most, with `clear` as a separate one-cycle pulse. The drop and saturation cases come from back-to-back bursts rather than from any illegal input.

// File: rtl/ort_pkg.sv
package ort_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE   = 2'd0,
    ENG_MATCH  = 2'd1,
    ENG_COMMIT = 2'd2
  } engState_t;

  // strobes sent from control to datapath each cycle
  typedef struct packed {
    logic bufLoad;   // capture incoming record into the buffer
    logic take;      // move buffer into the engine register
    logic latch;     // register match result and target index
    logic commit;    // apply update or allocation to the table
    logic clearAll;  // invalidate entries, restart round-robin
  } ortStrobe_t;

endpackage

// File: rtl/ort_ctrl.sv
module ort_ctrl
  import ort_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int GP_REG = 3,
  parameter int SP_REG = 2,
  parameter int DROP_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic              recValid,
  input  logic [REG_W-1:0]  recBaseReg,
  output ortStrobe_t        strobe,
  output logic [DROP_W-1:0] dropCount
);

  localparam logic [REG_W-1:0]  GP_IDX   = REG_W'(GP_REG);
  localparam logic [REG_W-1:0]  SP_IDX   = REG_W'(SP_REG);
  localparam logic [DROP_W-1:0] DROP_MAX = {DROP_W{1'b1}};

  engState_t state, stateNext;
  logic      bufValid;
  logic      ptrRelative;
  logic      wanted;
  logic      canTake;
  logic      hasSpace;
  logic      dropEvent;

  assign ptrRelative = (recBaseReg == GP_IDX) || (recBaseReg == SP_IDX);
  assign wanted      = recValid && !ptrRelative && !clear;
  assign canTake     = bufValid && !clear &&
                       ((state == ENG_IDLE) || (state == ENG_COMMIT));
  assign hasSpace    = !bufValid || canTake;
  assign dropEvent   = wanted && !hasSpace;

  always_comb begin
    strobe.bufLoad  = wanted && hasSpace;
    strobe.take     = canTake;
    strobe.latch    = (state == ENG_MATCH) && !clear;
    strobe.commit   = (state == ENG_COMMIT) && !clear;
    strobe.clearAll = clear;
  end

  always_comb begin
    if (clear)                  stateNext = ENG_IDLE;
    else if (canTake)           stateNext = ENG_MATCH;
    else if (state == ENG_MATCH) stateNext = ENG_COMMIT;
    else                        stateNext = ENG_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ENG_IDLE;
      bufValid <= 1'b0;
    end else begin
      state <= stateNext;
      if (clear) bufValid <= 1'b0;
      else       bufValid <= strobe.bufLoad || (bufValid && !canTake);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 dropCount <= '0;
    else if (dropEvent && dropCount != DROP_MAX) dropCount <= dropCount + 1'b1;
  end

endmodule

// File: rtl/ort_datapath.sv
module ort_datapath
  import ort_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 12,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ortStrobe_t               strobe,
  input  logic [ADDR_W-1:0]        recBase,
  input  logic signed [OFF_W-1:0]  recOffset,
  input  logic [IDX_W-1:0]         rdIdx,
  output logic                     rdValid,
  output logic [ADDR_W-1:0]        rdBase,
  output logic signed [OFF_W-1:0]  rdMin,
  output logic signed [OFF_W-1:0]  rdMax
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0]       entValid;
  logic [ADDR_W-1:0]        entBase [ENTRIES];
  logic signed [OFF_W-1:0]  entMin  [ENTRIES];
  logic signed [OFF_W-1:0]  entMax  [ENTRIES];

  logic [ADDR_W-1:0]        bufBase, engBase;
  logic signed [OFF_W-1:0]  bufOff,  engOff;

  logic [ENTRIES-1:0]       hitVec, freeVec;
  logic                     hitAny, freeAny;
  logic [IDX_W-1:0]         hitIdx, freeIdx, rrPtr;

  logic                     matchHit;
  logic [IDX_W-1:0]         matchIdx;

  // per-entry comparators
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hitVec[g]  = entValid[g] && (entBase[g] == engBase);
    assign freeVec[g] = !entValid[g];
  end

  // lowest-index priority encoders
  always_comb begin
    hitAny = 1'b0;
    hitIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        hitAny = 1'b1;
        hitIdx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    freeAny = 1'b0;
    freeIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (freeVec[i]) begin
        freeAny = 1'b1;
        freeIdx = IDX_W'(i);
      end
    end
  end

  // input buffer and engine record
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufBase <= '0;
      bufOff  <= '0;
      engBase <= '0;
      engOff  <= '0;
    end else begin
      if (strobe.bufLoad) begin
        bufBase <= recBase;
        bufOff  <= recOffset;
      end
      if (strobe.take) begin
        engBase <= bufBase;
        engOff  <= bufOff;
      end
    end
  end

  // match stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchHit <= 1'b0;
      matchIdx <= '0;
    end else if (strobe.latch) begin
      matchHit <= hitAny;
      if (hitAny)       matchIdx <= hitIdx;
      else if (freeAny) matchIdx <= freeIdx;
      else              matchIdx <= rrPtr;
    end
  end

  // commit stage: table storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entValid <= '0;
      rrPtr    <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        entBase[i] <= '0;
        entMin[i]  <= '0;
        entMax[i]  <= '0;
      end
    end else if (strobe.clearAll) begin
      entValid <= '0;
      rrPtr    <= '0;
    end else if (strobe.commit) begin
      if (matchHit) begin
        if (engOff < entMin[matchIdx]) entMin[matchIdx] <= engOff;
        if (engOff > entMax[matchIdx]) entMax[matchIdx] <= engOff;
      end else begin
        entValid[matchIdx] <= 1'b1;
        entBase[matchIdx]  <= engBase;
        entMin[matchIdx]   <= engOff;
        entMax[matchIdx]   <= engOff;
        rrPtr              <= (rrPtr == LAST_IDX) ? '0 : rrPtr + 1'b1;
      end
    end
  end

  // combinational read port
  assign rdValid = entValid[rdIdx];
  assign rdBase  = entBase[rdIdx];
  assign rdMin   = entMin[rdIdx];
  assign rdMax   = entMax[rdIdx];

endmodule

// File: rtl/obj_range_tracker.sv
module obj_range_tracker
  import ort_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 12,
  parameter int REG_W   = 5,
  parameter int GP_REG  = 3,
  parameter int SP_REG  = 2,
  parameter int DROP_W  = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     clear,
  input  logic                     recValid,
  input  logic [REG_W-1:0]         recBaseReg,
  input  logic [ADDR_W-1:0]        recBase,
  input  logic signed [OFF_W-1:0]  recOffset,
  input  logic [IDX_W-1:0]         rdIdx,
  output logic                     rdValid,
  output logic [ADDR_W-1:0]        rdBase,
  output logic signed [OFF_W-1:0]  rdMin,
  output logic signed [OFF_W-1:0]  rdMax,
  output logic [DROP_W-1:0]        dropCount
);

  ortStrobe_t strobe;

  ort_ctrl #(
    .REG_W (REG_W),
    .GP_REG(GP_REG),
    .SP_REG(SP_REG),
    .DROP_W(DROP_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .clear     (clear),
    .recValid  (recValid),
    .recBaseReg(recBaseReg),
    .strobe    (strobe),
    .dropCount (dropCount)
  );

  ort_datapath #(
    .ENTRIES(ENTRIES),
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .recBase  (recBase),
    .recOffset(recOffset),
    .rdIdx    (rdIdx),
    .rdValid  (rdValid),
    .rdBase   (rdBase),
    .rdMin    (rdMin),
    .rdMax    (rdMax)
  );

endmodule

// File: rtl/ort_checker.sv
module ort_checker
  import ort_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int OFF_W  = 12,
  parameter int DROP_W = 8,
  parameter int IDX_W  = 2,
  parameter int GP_REG = 3,
  parameter int SP_REG = 2
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     clear,
  input logic                     recValid,
  input logic [REG_W-1:0]         recBaseReg,
  input logic [IDX_W-1:0]         rdIdx,
  input logic                     rdValid,
  input logic signed [OFF_W-1:0]  rdMin,
  input logic signed [OFF_W-1:0]  rdMax,
  input logic [DROP_W-1:0]        dropCount,
  input ortStrobe_t               strobe
);

  logic ptrRec;
  assign ptrRec = recValid &&
                  ((recBaseReg == REG_W'(GP_REG)) || (recBaseReg == REG_W'(SP_REG)));

  // R3
  minmax_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (rdMin <= rdMax));

  // R4
  ptr_noload_chk: assert property (@(posedge clk) disable iff (!rstN)
    ptrRec |-> !strobe.bufLoad);

  // R4
  ptr_nodrop_chk: assert property (@(posedge clk) disable iff (!rstN)
    ptrRec |=> $stable(dropCount));

  // R6
  drop_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dropCount) |-> (dropCount == DROP_W'($past(dropCount) + 1'b1)));

  // R6
  pipe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.latch, strobe.commit}));

  // R7
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> !rdValid);

  // R7
  clear_keepdrop_chk: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> $stable(dropCount));

  // R2
  alloc_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rdValid) && $stable(rdIdx)) |-> $past(strobe.commit));

endmodule

bind obj_range_tracker ort_checker #(
  .REG_W (REG_W),
  .OFF_W (OFF_W),
  .DROP_W(DROP_W),
  .IDX_W (IDX_W),
  .GP_REG(GP_REG),
  .SP_REG(SP_REG)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .clear     (clear),
  .recValid  (recValid),
  .recBaseReg(recBaseReg),
  .rdIdx     (rdIdx),
  .rdValid   (rdValid),
  .rdMin     (rdMin),
  .rdMax     (rdMax),
  .dropCount (dropCount),
  .strobe    (strobe)
);

// File: tb/tb_obj_range_tracker.sv
`timescale 1ns/1ps
module tb_obj_range_tracker;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                clear = 1'b0;
  logic                recValid = 1'b0;
  logic [4:0]          recBaseReg = '0;
  logic [31:0]         recBase = '0;
  logic signed [11:0]  recOffset = '0;
  logic [1:0]          rdIdx = '0;
  logic                rdValid;
  logic [31:0]         rdBase;
  logic signed [11:0]  rdMin, rdMax;
  logic [7:0]          dropCount;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  obj_range_tracker dut (
    .clk(clk), .rstN(rstN), .clear(clear), .recValid(recValid),
    .recBaseReg(recBaseReg), .recBase(recBase), .recOffset(recOffset),
    .rdIdx(rdIdx), .rdValid(rdValid), .rdBase(rdBase),
    .rdMin(rdMin), .rdMax(rdMax), .dropCount(dropCount)
  );

  typedef struct packed {
    logic [4:0]         rg;
    logic [31:0]        base;
    logic signed [11:0] off;
    logic [1:0]         idx;
    logic               expV;
    logic [31:0]        expBase;
    logic signed [11:0] expMin;
    logic signed [11:0] expMax;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{5'd10, 32'd1000, 12'sd16,   2'd0, 1'b1, 32'd1000, 12'sd16,   12'sd16},   // R2 first alloc
    '{5'd10, 32'd1000, -12'sd8,   2'd0, 1'b1, 32'd1000, -12'sd8,   12'sd16},   // R3 lower min
    '{5'd11, 32'd1000, 12'sd40,   2'd0, 1'b1, 32'd1000, -12'sd8,   12'sd40},   // R3 other reg raises max
    '{5'd10, 32'd1000, 12'sd4,    2'd0, 1'b1, 32'd1000, -12'sd8,   12'sd40},   // R3 inside window
    '{5'd2,  32'd2000, 12'sd0,    2'd1, 1'b0, 32'd0,    12'sd0,    12'sd0},    // R4 stack reg
    '{5'd3,  32'd1000, 12'sd100,  2'd0, 1'b1, 32'd1000, -12'sd8,   12'sd40},   // R4 global reg
    '{5'd12, 32'd2000, 12'sd0,    2'd1, 1'b1, 32'd2000, 12'sd0,    12'sd0},    // R2 second alloc
    '{5'd12, 32'd3000, 12'h800,   2'd2, 1'b1, 32'd3000, 12'h800,   12'h800},   // R3 most negative
    '{5'd12, 32'd4000, 12'sd2047, 2'd3, 1'b1, 32'd4000, 12'sd2047, 12'sd2047}, // R3 most positive
    '{5'd13, 32'd5000, 12'sd7,    2'd0, 1'b1, 32'd5000, 12'sd7,    12'sd7},    // R5 evict oldest
    '{5'd13, 32'd6000, 12'sd1,    2'd1, 1'b1, 32'd6000, 12'sd1,    12'sd1},    // R5 next victim
    '{5'd13, 32'd2000, 12'sd5,    2'd2, 1'b1, 32'd2000, 12'sd5,    12'sd5},    // R5 evicted base misses
    '{5'd13, 32'd3000, 12'sd0,    2'd3, 1'b1, 32'd3000, 12'sd0,    12'sd0}     // R5 wrap of victims
  };

  task automatic check(input string tag, input longint got, input longint exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic sendRec(input logic [4:0] rg, input logic [31:0] b, input logic signed [11:0] o);
    @(negedge clk);
    recValid = 1'b1; recBaseReg = rg; recBase = b; recOffset = o;
    @(negedge clk);
    recValid = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic pulseClear();
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  task automatic readEntry(input logic [1:0] i, input string tag, input bit v,
                           input logic [31:0] b, input int mn, input int mx);
    rdIdx = i;
    #1;
    check({tag, " valid"}, rdValid, v);
    if (v) begin
      check({tag, " base"}, rdBase, b);
      check({tag, " min"}, rdMin, mn);
      check({tag, " max"}, rdMax, mx);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 4; i++) readEntry(2'(i), "R1 entry", 1'b0, 0, 0, 0);
    check("R1 dropCount", dropCount, 0);

    // vector table: R2 R3 R4 R5 R8
    for (int k = 0; k < NV; k++) begin
      sendRec(VECS[k].rg, VECS[k].base, VECS[k].off);
      settle();
      readEntry(VECS[k].idx, $sformatf("R8 vec%0d", k), VECS[k].expV,
                VECS[k].expBase, VECS[k].expMin, VECS[k].expMax);
    end
    check("R6 no drops when spaced", dropCount, 0);

    // R7 clear empties table, keeps count
    pulseClear();
    for (int i = 0; i < 4; i++) readEntry(2'(i), "R7 cleared", 1'b0, 0, 0, 0);

    // R4 pointer-relative burst is never buffered nor counted
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      recValid = 1'b1; recBaseReg = (i % 2 == 0) ? 5'd2 : 5'd3;
      recBase = 32'h50 + 32'(i); recOffset = 12'sd1;
      @(negedge clk);
    end
    recValid = 1'b0;
    settle();
    check("R4 burst no drops", dropCount, 0);
    readEntry(2'd0, "R4 burst no alloc", 1'b0, 0, 0, 0);

    // R6 burst of five: A,B,D kept, C,E dropped
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      recValid = 1'b1; recBaseReg = 5'd10;
      recBase = 32'h100 * (i + 1); recOffset = 12'(i);
      @(negedge clk);
    end
    recValid = 1'b0;
    repeat (6) @(negedge clk);
    check("R6 burst drops", dropCount, 2);
    readEntry(2'd0, "R6 A", 1'b1, 32'h100, 0, 0);
    readEntry(2'd1, "R6 B", 1'b1, 32'h200, 1, 1);
    readEntry(2'd2, "R6 D", 1'b1, 32'h400, 3, 3);
    readEntry(2'd3, "R6 slot3", 1'b0, 0, 0, 0);

    // R7 clear with a simultaneous record, then fresh allocation at entry 0
    @(negedge clk);
    clear = 1'b1; recValid = 1'b1; recBaseReg = 5'd10; recBase = 32'h777; recOffset = 12'sd9;
    @(negedge clk);
    clear = 1'b0; recValid = 1'b0;
    settle();
    readEntry(2'd0, "R7 same-cycle record discarded", 1'b0, 0, 0, 0);
    check("R7 dropCount kept", dropCount, 2);
    sendRec(5'd10, 32'h700, 12'sd3);
    settle();
    readEntry(2'd0, "R7 rr restart", 1'b1, 32'h700, 3, 3);

    // R7 in-flight record flushed
    sendRec(5'd10, 32'h800, 12'sd2);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    settle();
    for (int i = 0; i < 4; i++) readEntry(2'(i), "R7 inflight flushed", 1'b0, 0, 0, 0);

    // R6 saturation of the drop counter
    @(negedge clk);
    for (int i = 0; i < 600; i++) begin
      recValid = 1'b1; recBaseReg = 5'd10;
      recBase = 32'h9000 + 32'(i); recOffset = 12'sd0;
      @(negedge clk);
    end
    recValid = 1'b0;
    settle();
    check("R6 saturation", dropCount, 255);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule